// File: doc/BRIEF.md
# Video Encoder Host Register Port

This block is the 8-bit host-side register port of a video encoder. A host processor makes each access by lowering chip select. The levels of the read/write line and the register-select line at that falling edge decide what the access is. A write stores the data byte in one of two places: the address pointer, or the control register that the pointer names. A read drives either the pointer or the addressed register onto the data bus. The bus is held there until chip select rises again.

The port also works as a test tap into the video path. Suppose the test register holds code 0x28 and the pointer holds 0x40 or 0x60. A register-data read then stops returning a static value. The bus instead streams the top eight bits of the composite or luminance sample, taking a new value on every master clock. The stream ends when chip select rises. The pointer keeps its value, so lowering chip select again restarts the stream.

The host pins are not related to the video clock. They pass through a two-stage synchronizer before any edge is detected. The enable and data outputs are registered. Reset clears only the soft-reset bit of the global control register. All other register contents survive it.

Top module: `vid_host_port`

## Requirements
- R1: A write with addrSel=0 (rdWrN=0 at the chip-select falling edge) loads dataIn into the address pointer. A read with addrSel=0 returns the pointer value.
- R2: A write with addrSel=1 loads dataIn into control register number pointer, if the pointer is below NREGS (register 0 is the global control register, shown on globalCtrl). A write with the pointer at or above NREGS changes no register.
- R3: A read with addrSel=1 outside monitor mode returns the control register at the pointer, or 0x00 when the pointer is at or above NREGS.
- R4: The chip-select falling edge reaches the outputs after the synchronizer stages plus one register: with the default two stages, dataOe and valid dataOut appear on the third rising clock edge after csN falls. In a normal read, dataOut then stays constant for as long as csN stays low.
- R5: After csN rises, dataOe falls on the third rising clock edge. Whenever dataOe is low, dataOut is 0x00.
- R6: Monitor mode for the composite sample holds when the test register (address TEST_ADDR, default 7) holds 0x28, the pointer holds 0x40 and a read with addrSel=1 starts. On every clock edge while the read lasts, dataOut takes compSample[SAMPLE_W-1:SAMPLE_W-8].
- R7: With the test register at 0x28 and the pointer at 0x60, such a read instead streams lumaSample[SAMPLE_W-1:SAMPLE_W-8] on every clock edge.
- R8: If the test register does not hold 0x28, a read at pointer 0x40 does not stream. It returns 0x00 and holds it.
- R9: A low rstN (synchronous, active low) clears bit 4 of the global control register and drops dataOe on the next edge. The other bits of register 0, every other control register and the pointer are kept.
- R10: A monitor access leaves the pointer unchanged. Lowering csN again restarts the same stream without rewriting the pointer.
- R11: rdWrN and addrSel are used only at the chip-select falling edge. Changing them while csN is low neither stops the read in progress nor writes any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master video clock |
| rstN | input | 1 | Synchronous active-low reset |
| csN | input | 1 | Chip select, active low, asynchronous to clk |
| rdWrN | input | 1 | 1 = read, 0 = write, taken at the csN falling edge |
| addrSel | input | 1 | 0 = address pointer, 1 = register data |
| dataIn | input | 8 | Write data from the host |
| compSample | input | SAMPLE_W | Upsampled composite sample from the video path |
| lumaSample | input | SAMPLE_W | Luminance sample before sync and blank insertion |
| dataOut | output | 8 | Read data or monitor stream |
| dataOe | output | 1 | Drive enable for the external data bus |
| globalCtrl | output | 8 | Current global control register (address 0) |

## Verification
The bench uses the default parameters: NREGS=8, TEST_ADDR=7, two synchronizer stages and SAMPLE_W=10. A 10-bit sample makes a wrong slice visible, because the streamed byte must match the top eight bits and not the low ones. Eight registers put both monitor pointers (0x40 and 0x60) outside the register file. This exposes the difference between the 0x00 of an out-of-range read and a real stream. Two stages fix the enable latency at three edges, and the bench checks that latency exactly, one cycle before and at the edge.

// File: rtl/vid_host_port_pkg.sv
package vid_host_port_pkg;
  localparam int BUS_W = 8;
  localparam logic [BUS_W-1:0] MON_TEST_CODE = 8'h28;
  localparam logic [BUS_W-1:0] MON_COMP_PTR  = 8'h40;
  localparam logic [BUS_W-1:0] MON_LUMA_PTR  = 8'h60;

  typedef enum logic [1:0] {
    MON_OFF  = 2'd0,
    MON_COMP = 2'd1,
    MON_LUMA = 2'd2
  } monMode_e;

  typedef struct packed {
    logic loadPtr;
    logic loadReg;
    logic startRead;
    logic stopRead;
    logic readSel;
  } hostStrobe_t;
endpackage

// File: rtl/vid_host_sync.sv
module vid_host_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rstN) stage[s] <= RST_VAL;
        else if (s == 0) stage[s] <= din;
        else stage[s] <= stage[(s > 0) ? s - 1 : 0];
      end
    end
  endgenerate

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/vid_host_ctrl.sv
module vid_host_ctrl
  import vid_host_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             rdWrN,
  input  logic             addrSel,
  input  logic [BUS_W-1:0] dataIn,
  output hostStrobe_t      strobe,
  output logic [BUS_W-1:0] wrData,
  output logic             readActive
);
  localparam int SW = BUS_W + 3;

  logic [SW-1:0] syncOut;
  logic csS, rwS, selS, csPrev, csFall;

  vid_host_sync #(
    .W(SW),
    .STAGES(SYNC_STAGES),
    .RST_VAL({3'b110, {BUS_W{1'b0}}})
  ) u_sync (
    .clk(clk),
    .rstN(rstN),
    .din({csN, rdWrN, addrSel, dataIn}),
    .dout(syncOut)
  );

  assign {csS, rwS, selS, wrData} = syncOut;

  always_ff @(posedge clk) begin
    if (!rstN) csPrev <= 1'b1;
    else csPrev <= csS;
  end

  assign csFall = csPrev & ~csS;

  always_comb begin
    strobe.loadPtr   = csFall & ~rwS & ~selS;
    strobe.loadReg   = csFall & ~rwS & selS;
    strobe.startRead = csFall & rwS;
    strobe.stopRead  = readActive & csS;
    strobe.readSel   = selS;
  end

  always_ff @(posedge clk) begin
    if (!rstN) readActive <= 1'b0;
    else if (strobe.startRead) readActive <= 1'b1;
    else if (strobe.stopRead) readActive <= 1'b0;
  end

  // R5: chip select held high for three samples leaves no read open
  a_r5_cs_high_closes: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2)) |=> !readActive);

  // R11: at most one access action per cycle
  a_r11_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadPtr, strobe.loadReg, strobe.startRead, strobe.stopRead}));
endmodule

// File: rtl/vid_host_dp.sv
module vid_host_dp
  import vid_host_port_pkg::*;
#(
  parameter int NREGS = 8,
  parameter int TEST_ADDR = 7,
  parameter int GLOBAL_ADDR = 0,
  parameter int SRST_BIT = 4,
  parameter int SAMPLE_W = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  hostStrobe_t         strobe,
  input  logic [BUS_W-1:0]    wrData,
  input  logic [SAMPLE_W-1:0] compSample,
  input  logic [SAMPLE_W-1:0] lumaSample,
  output logic [BUS_W-1:0]    dataOut,
  output logic                dataOe,
  output logic [BUS_W-1:0]    globalCtrl
);
  localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1;

  logic [BUS_W-1:0] ptrReg;
  logic [BUS_W-1:0] regs [NREGS];
  logic [IDX_W-1:0] regIdx;
  logic             ptrHit;
  logic [BUS_W-1:0] testWord, readValue, compTop, lumaTop;
  monMode_e         modeReg, nextMode;
  logic             unusedLowBits;

  assign regIdx   = ptrReg[IDX_W-1:0];
  assign ptrHit   = int'(ptrReg) < NREGS;
  assign testWord = regs[TEST_ADDR];
  assign compTop  = compSample[SAMPLE_W-1 -: BUS_W];
  assign lumaTop  = lumaSample[SAMPLE_W-1 -: BUS_W];
  assign unusedLowBits = ^{compSample[SAMPLE_W-BUS_W-1:0], lumaSample[SAMPLE_W-BUS_W-1:0]};
  assign globalCtrl = regs[GLOBAL_ADDR];

  // pointer survives reset and every access
  always_ff @(posedge clk) begin
    if (rstN && strobe.loadPtr) ptrReg <= wrData;
  end

  // only the soft-reset bit of the global register is cleared by reset
  always_ff @(posedge clk) begin
    if (!rstN) regs[GLOBAL_ADDR][SRST_BIT] <= 1'b0;
    else if (strobe.loadReg && ptrHit) regs[regIdx] <= wrData;
  end

  always_comb begin
    nextMode = MON_OFF;
    if (strobe.readSel && testWord == MON_TEST_CODE) begin
      if (ptrReg == MON_COMP_PTR) nextMode = MON_COMP;
      else if (ptrReg == MON_LUMA_PTR) nextMode = MON_LUMA;
    end
  end

  always_comb begin
    if (!strobe.readSel) readValue = ptrReg;
    else if (ptrHit) readValue = regs[regIdx];
    else readValue = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOe  <= 1'b0;
      dataOut <= '0;
      modeReg <= MON_OFF;
    end else if (strobe.startRead) begin
      dataOe  <= 1'b1;
      modeReg <= nextMode;
      unique case (nextMode)
        MON_COMP: dataOut <= compTop;
        MON_LUMA: dataOut <= lumaTop;
        default:  dataOut <= readValue;
      endcase
    end else if (strobe.stopRead) begin
      dataOe  <= 1'b0;
      dataOut <= '0;
      modeReg <= MON_OFF;
    end else if (dataOe) begin
      unique case (modeReg)
        MON_COMP: dataOut <= compTop;
        MON_LUMA: dataOut <= lumaTop;
        default:  dataOut <= dataOut;
      endcase
    end
  end

  // R4: a normal read holds its byte until the stop
  a_r4_hold_value: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && modeReg == MON_OFF && !strobe.stopRead) |=> $stable(dataOut));

  // R5: an idle bus carries zero
  a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !dataOe |-> dataOut == '0);

  // R6: composite stream follows the previous-cycle sample
  a_r6_comp_stream: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && modeReg == MON_COMP) |-> dataOut == $past(compSample[SAMPLE_W-1 -: BUS_W]));

  // R7: luminance stream follows the previous-cycle sample
  a_r7_luma_stream: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && modeReg == MON_LUMA) |-> dataOut == $past(lumaSample[SAMPLE_W-1 -: BUS_W]));

  // R9: leaving reset, the soft-reset bit is clear
  a_r9_soft_reset_bit: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !regs[GLOBAL_ADDR][SRST_BIT]);

  // R10: the end of a read leaves the pointer alone
  a_r10_ptr_kept: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stopRead |=> $stable(ptrReg));
endmodule

// File: rtl/vid_host_port.sv
module vid_host_port
  import vid_host_port_pkg::*;
#(
  parameter int NREGS = 8,
  parameter int TEST_ADDR = 7,
  parameter int SAMPLE_W = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                csN,
  input  logic                rdWrN,
  input  logic                addrSel,
  input  logic [7:0]          dataIn,
  input  logic [SAMPLE_W-1:0] compSample,
  input  logic [SAMPLE_W-1:0] lumaSample,
  output logic [7:0]          dataOut,
  output logic                dataOe,
  output logic [7:0]          globalCtrl
);
  hostStrobe_t      strobe;
  logic [BUS_W-1:0] wrData;
  logic             readActive;

  vid_host_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .csN(csN),
    .rdWrN(rdWrN),
    .addrSel(addrSel),
    .dataIn(dataIn),
    .strobe(strobe),
    .wrData(wrData),
    .readActive(readActive)
  );

  vid_host_dp #(
    .NREGS(NREGS),
    .TEST_ADDR(TEST_ADDR),
    .GLOBAL_ADDR(0),
    .SRST_BIT(4),
    .SAMPLE_W(SAMPLE_W)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .wrData(wrData),
    .compSample(compSample),
    .lumaSample(lumaSample),
    .dataOut(dataOut),
    .dataOe(dataOe),
    .globalCtrl(globalCtrl)
  );

  // R4: a read start drives the bus on the next edge
  a_r4_start_drives: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startRead |=> dataOe);

  // R5: the enable tracks the open read
  a_r5_oe_matches: assert property (@(posedge clk) disable iff (!rstN)
    dataOe == readActive);
endmodule

// File: tb/vid_host_port_tb.sv
module vid_host_port_tb;
  localparam int SW = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic rdWrN = 1'b1;
  logic addrSel = 1'b0;
  logic [7:0] dataIn = '0;
  logic [SW-1:0] compSample = '0;
  logic [SW-1:0] lumaSample = '0;
  logic [7:0] dataOut, globalCtrl;
  logic dataOe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  vid_host_port u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .rdWrN(rdWrN), .addrSel(addrSel),
    .dataIn(dataIn), .compSample(compSample), .lumaSample(lumaSample),
    .dataOut(dataOut), .dataOe(dataOe), .globalCtrl(globalCtrl)
  );

  always #4 clk = ~clk;

  localparam logic [7:0] TBL_PTR  [6] = '{8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd6};
  localparam logic [7:0] TBL_DATA [6] = '{8'hA5, 8'h3C, 8'h5A, 8'hC3, 8'h0F, 8'h81};

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic hostWrite(input logic sel, input logic [7:0] val);
    @(negedge clk);
    addrSel = sel; rdWrN = 1'b0; dataIn = val; csN = 1'b0;
    repeat (4) @(negedge clk);
    csN = 1'b1;
    repeat (4) @(negedge clk);
    rdWrN = 1'b1;
  endtask

  task automatic hostRead(input logic sel, output logic [7:0] val);
    @(negedge clk);
    addrSel = sel; rdWrN = 1'b1; csN = 1'b0;
    repeat (3) @(negedge clk);
    val = dataOut;
    csN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [SW-1:0] pat(input int k, input int salt);
    return SW'((k * 173 + salt * 91 + 57) & 10'h3FF);
  endfunction

  // lower csN and check the streamed byte for n samples; src 0 = comp, 1 = luma
  task automatic streamCheck(input int src, input int n, input string req, input int salt);
    logic [SW-1:0] last;
    @(negedge clk);
    addrSel = 1'b1; rdWrN = 1'b1; csN = 1'b0;
    last = pat(0, salt);
    if (src == 0) compSample = last; else lumaSample = last;
    for (int k = 1; k < n + 3; k++) begin
      @(negedge clk);
      if (k >= 3) check(req, dataOut, last[SW-1 -: 8]);
      last = pat(k, salt);
      if (src == 0) begin
        compSample = last; lumaSample = ~last;
      end else begin
        lumaSample = last; compSample = ~last;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    logic [7:0] rd;
    repeat (4) @(negedge clk);
    check("R5 reset oe", {7'b0, dataOe}, 8'h00);
    check("R5 reset data", dataOut, 8'h00);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R2 R3: table of register writes then readback
    for (int i = 0; i < 6; i++) begin
      hostWrite(1'b0, TBL_PTR[i]);
      hostWrite(1'b1, TBL_DATA[i]);
    end
    hostWrite(1'b0, 8'd0);
    hostWrite(1'b1, 8'h00);
    hostWrite(1'b0, 8'd7);
    hostWrite(1'b1, 8'h11);
    for (int i = 0; i < 6; i++) begin
      hostWrite(1'b0, TBL_PTR[i]);
      hostRead(1'b0, rd);
      check("R1 pointer readback", rd, TBL_PTR[i]);
      hostRead(1'b1, rd);
      check("R3 register readback", rd, TBL_DATA[i]);
    end
    check("R2 global reg", globalCtrl, 8'h00);

    // R4 latency and hold, R5 release timing
    hostWrite(1'b0, 8'd3);
    @(negedge clk);
    addrSel = 1'b1; rdWrN = 1'b1; csN = 1'b0;
    repeat (2) @(negedge clk);
    check("R4 oe not yet", {7'b0, dataOe}, 8'h00);
    @(negedge clk);
    check("R4 oe on third edge", {7'b0, dataOe}, 8'h01);
    check("R4 data valid", dataOut, 8'h5A);
    repeat (6) @(negedge clk);
    check("R4 data held", dataOut, 8'h5A);
    csN = 1'b1;
    repeat (2) @(negedge clk);
    check("R5 oe still on", {7'b0, dataOe}, 8'h01);
    @(negedge clk);
    check("R5 oe off third edge", {7'b0, dataOe}, 8'h00);
    check("R5 idle zero", dataOut, 8'h00);
    repeat (2) @(negedge clk);

    // R8 and R2 out of range: test register not at the monitor code
    hostWrite(1'b0, 8'h40);
    hostWrite(1'b1, 8'h99);
    @(negedge clk);
    addrSel = 1'b1; rdWrN = 1'b1; csN = 1'b0;
    for (int k = 0; k < 8; k++) begin
      compSample = pat(k, 3);
      @(negedge clk);
      if (k >= 3) check("R8 no stream at 0x40", dataOut, 8'h00);
    end
    csN = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 out of range write ignored", globalCtrl, 8'h00);
    hostWrite(1'b0, 8'd7);
    hostRead(1'b1, rd);
    check("R2 test reg untouched", rd, 8'h11);

    // R6 composite stream
    hostWrite(1'b1, 8'h28);
    hostWrite(1'b0, 8'h40);
    streamCheck(0, 8, "R6 composite stream", 1);
    csN = 1'b1;
    repeat (2) @(negedge clk);
    check("R6 stream until release", {7'b0, dataOe}, 8'h01);
    @(negedge clk);
    check("R5 stream release", {7'b0, dataOe}, 8'h00);
    repeat (2) @(negedge clk);

    // R10 restart without rewriting the pointer
    streamCheck(0, 4, "R10 restarted stream", 5);
    csN = 1'b1;
    repeat (4) @(negedge clk);
    hostRead(1'b0, rd);
    check("R10 pointer kept", rd, 8'h40);

    // R7 luminance stream
    hostWrite(1'b0, 8'h60);
    streamCheck(1, 8, "R7 luma stream", 2);
    csN = 1'b1;
    repeat (4) @(negedge clk);

    // R11 rdWrN and data changes during an open read
    hostWrite(1'b0, 8'd2);
    @(negedge clk);
    addrSel = 1'b1; rdWrN = 1'b1; csN = 1'b0;
    repeat (4) @(negedge clk);
    rdWrN = 1'b0; addrSel = 1'b0; dataIn = 8'h33;
    repeat (5) @(negedge clk);
    check("R11 read not disturbed", dataOut, 8'h3C);
    check("R11 oe kept", {7'b0, dataOe}, 8'h01);
    csN = 1'b1;
    repeat (4) @(negedge clk);
    rdWrN = 1'b1;
    hostRead(1'b0, rd);
    check("R11 pointer not written", rd, 8'd2);
    hostRead(1'b1, rd);
    check("R11 register not written", rd, 8'h3C);

    // R9 reset keeps all but the soft-reset bit
    hostWrite(1'b0, 8'd0);
    hostWrite(1'b1, 8'hFF);
    check("R2 global written", globalCtrl, 8'hFF);
    hostWrite(1'b0, 8'd3);
    @(negedge clk);
    addrSel = 1'b1; rdWrN = 1'b1; csN = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R9 oe dropped by reset", {7'b0, dataOe}, 8'h00);
    csN = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 soft reset bit cleared", globalCtrl, 8'hEF);
    hostRead(1'b0, rd);
    check("R9 pointer kept", rd, 8'd3);
    hostRead(1'b1, rd);
    check("R9 register kept", rd, 8'h5A);
    hostWrite(1'b0, 8'd7);
    hostRead(1'b1, rd);
    check("R9 test reg kept", rd, 8'h28);

    finishRun();
  end
endmodule